// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block collects level-sensitive interrupt lines and drives one interrupt output per CPU in a small multiprocessor. Every source has to pass two gates before it reaches a CPU. The first gate is a global enable that all CPUs share. The second is a mask that each CPU holds for itself. A source interrupts a CPU only while its line is high, its global enable is set and that CPU has it unmasked. Each CPU also has a bank of doorbell bits that software can raise through a trigger register.

Software reaches the block through a single-cycle bus port that carries the number of the requesting CPU. Addresses below 0x800 form the shared main space. Addresses from 0x800 upward form a per-CPU window. The block steers every access to that window to the registers of the CPU named on the bus. Sources 0 to 27 are private to each CPU: every CPU has its own line for each of them. Sources from 28 upward have one shared line. For a shared source, a routing register sets the per-CPU mask bits of all CPUs in one write.

Software services an interrupt by reading the acknowledge register in the window. That read returns the lowest-numbered source that currently qualifies for the CPU doing the read. Register reads are combinational and have no side effects. The interrupt outputs are registered.

Top module: `dual_mask_intc`

## Requirements
- R1: After reset, all global enables, per-CPU masks (masked), routing bits, doorbell causes and doorbell masks are zero, every `irq_o` bit is 0, and the acknowledge read returns 0x3FF.
- R2: Writing a source number to main offset 0x030 sets that source's global enable, and writing it to 0x034 clears it. A source reaches a CPU only when its line is high, it is globally enabled and that CPU has it unmasked.
- R3: Writing a source number to window offset 0x048 (address 0x848) unmasks it, and writing it to 0x04C masks it. Either write affects only the CPU given on `bus_cpu_i`.
- R4: For a shared source n (n >= 28), writing main offset 0x100+4n sets CPU c's mask bit for n to `wdata[c]`. Reading that offset returns CPU c's mask bit for n in bit c.
- R5: Private source n (n < 28) for CPU c comes from `src_pcpu_i[c*28+n]` and reaches only CPU c. A routing write to a private source has no effect.
- R6: A read of window offset 0x044 returns, in bits [9:0], the lowest-numbered qualifying source for the requesting CPU, or 0x3FF when there is none.
- R7: A write to main offset 0x004 ORs `wdata[7:0]` into the doorbell cause of every CPU c whose bit `wdata[16+c]` is set. The cause reads at window offset 0x008.
- R8: A write to window offset 0x008 clears the requesting CPU's cause bits that are written 0 and keeps the bits written 1.
- R9: Window offset 0x00C is the requesting CPU's doorbell enable (1 = enabled). A CPU's interrupt output is also asserted when any of its cause bits is set and enabled.
- R10: `irq_o` is registered. It reflects a line change at the next clock edge, and a register write one edge after the edge that performs the write.
- R11: An enable or mask write whose full 32-bit data is not below the number of sources changes nothing.
- R12: Main offset 0x000 reads the number of sources in bits [7:0] and the number of CPUs in bits [11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_glb_i | input | NUM_SRC-PCPU_SRC | Shared source lines, bit k is source PCPU_SRC+k |
| src_pcpu_i | input | NUM_CPUS*PCPU_SRC | Private source lines, CPU c at [c*PCPU_SRC +: PCPU_SRC] |
| bus_req_i | input | 1 | Access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_cpu_i | input | $clog2(NUM_CPUS) | Number of the requesting CPU |
| bus_addr_i | input | 12 | Byte address; bit 11 selects the per-CPU window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | NUM_CPUS | Interrupt output per CPU |

## Verification
The bench aims at the cases where the two gates or the window steering are easy to get wrong. A source that is only globally enabled, or only unmasked, must stay silent. A design that ORs the two levels instead of ANDing them would raise the output early. A mask write from one CPU must leave the other CPU's state untouched, or the wrong output goes up. Source numbers above the valid range, such as 76, must not alias onto a low source through truncation; a truncating design would enable source 12. Routing writes to private sources must read back zero. The bench also checks the exact latency of the output register, the lowest-first order of the acknowledge read, and the write-zero-to-clear rule for doorbell causes, against a reference model under random stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [10:0] OFF_CTRL     = 11'h000;
  localparam logic [10:0] OFF_SW_TRIG  = 11'h004;
  localparam logic [10:0] OFF_GEN_SET  = 11'h030;
  localparam logic [10:0] OFF_GEN_CLR  = 11'h034;
  localparam logic [10:0] WOFF_DB_CAUSE = 11'h008;
  localparam logic [10:0] WOFF_DB_EN   = 11'h00C;
  localparam logic [10:0] WOFF_ACK     = 11'h044;
  localparam logic [10:0] WOFF_UNMASK  = 11'h048;
  localparam logic [10:0] WOFF_MASK    = 11'h04C;
  localparam logic [2:0]  ROUTE_PAGE   = 3'b001;
  localparam logic [9:0]  ACK_NONE     = 10'h3FF;
  localparam int unsigned TRIG_TGT_LSB = 16;
endpackage

// File: rtl/intc_lowest_find.sv
module intc_lowest_find
  import intc_pkg::*;
#(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] vec_i,
  output logic [9:0]   code_o
);
  always_comb begin
    code_o = ACK_NONE;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = 10'(i);
    end
  end
endmodule

// File: rtl/intc_cpu_gate.sv
module intc_cpu_gate #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic [NUM_SRC-1:0] lines_i,
  input  logic [NUM_SRC-1:0] glb_en_i,
  input  logic [NUM_SRC-1:0] unmask_i,
  output logic               any_o,
  output logic [9:0]         first_o
);
  logic [NUM_SRC-1:0] qual;

  assign qual  = lines_i & glb_en_i & unmask_i;
  assign any_o = |qual;

  intc_lowest_find #(.W(NUM_SRC)) u_find (
    .vec_i (qual),
    .code_o(first_o)
  );
endmodule

// File: rtl/intc_doorbell.sv
module intc_doorbell #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            cause_we_i,
  input  logic            en_we_i,
  input  logic [DB_W-1:0] wdata_i,
  output logic [DB_W-1:0] cause_o,
  output logic [DB_W-1:0] en_o,
  output logic            hit_o
);
  logic [DB_W-1:0] cause_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      en_q    <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      if (trig_i)          cause_q <= cause_q | wdata_i;
      else if (cause_we_i) cause_q <= cause_q & wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign en_o    = en_q;
  assign hit_o   = |(cause_q & en_q);
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned NUM_SRC  = 40,
  parameter int unsigned PCPU_SRC = 28,
  parameter int unsigned DB_W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SRC-PCPU_SRC-1:0]  src_glb_i,
  input  logic [NUM_CPUS*PCPU_SRC-1:0] src_pcpu_i,
  input  logic                         bus_req_i,
  input  logic                         bus_we_i,
  input  logic [$clog2(NUM_CPUS)-1:0]  bus_cpu_i,
  input  logic [11:0]                  bus_addr_i,
  input  logic [31:0]                  bus_wdata_i,
  output logic [31:0]                  bus_rdata_o,
  output logic [NUM_CPUS-1:0]          irq_o
);
  localparam int unsigned CPU_W = $clog2(NUM_CPUS);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]                glb_en_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  unmask_q;
  logic [NUM_CPUS-1:0]               src_hit, db_hit, hit, irq_q;
  logic [NUM_CPUS-1:0][9:0]          first_code;
  logic [NUM_CPUS-1:0][DB_W-1:0]     db_cause, db_en;

  logic              wr, win, num_ok, route_hit, route_ok, route_glb;
  logic [10:0]       offs;
  logic [IDX_W-1:0]  num, route_idx;

  assign wr        = bus_req_i & bus_we_i;
  assign win       = bus_addr_i[11];
  assign offs      = bus_addr_i[10:0];
  assign num_ok    = bus_wdata_i < 32'(NUM_SRC);
  assign num       = bus_wdata_i[IDX_W-1:0];
  assign route_hit = (offs[10:8] == ROUTE_PAGE);
  assign route_idx = offs[2 +: IDX_W];
  assign route_ok  = int'(offs[7:2]) < NUM_SRC;
  assign route_glb = int'(offs[7:2]) >= PCPU_SRC;

  // global enable level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= '0;
    end else if (wr && !win && num_ok) begin
      if (offs == OFF_GEN_SET)      glb_en_q[num] <= 1'b1;
      else if (offs == OFF_GEN_CLR) glb_en_q[num] <= 1'b0;
    end
  end

  // per-CPU mask level: aliased window writes and shared-source routing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unmask_q <= '0;
    end else begin
      if (wr && win && num_ok && (offs == WOFF_UNMASK || offs == WOFF_MASK))
        unmask_q[bus_cpu_i][num] <= (offs == WOFF_UNMASK);
      if (wr && !win && route_hit && route_ok && route_glb)
        for (int c = 0; c < NUM_CPUS; c++) unmask_q[c][route_idx] <= bus_wdata_i[c];
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] lines;
    logic               own;

    assign lines = {src_glb_i, src_pcpu_i[c*PCPU_SRC +: PCPU_SRC]};
    assign own   = (bus_cpu_i == CPU_W'(c));

    intc_cpu_gate #(.NUM_SRC(NUM_SRC)) u_gate (
      .lines_i (lines),
      .glb_en_i(glb_en_q),
      .unmask_i(unmask_q[c]),
      .any_o   (src_hit[c]),
      .first_o (first_code[c])
    );

    intc_doorbell #(.DB_W(DB_W)) u_db (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (wr && !win && offs == OFF_SW_TRIG && bus_wdata_i[TRIG_TGT_LSB + c]),
      .cause_we_i(wr && win && offs == WOFF_DB_CAUSE && own),
      .en_we_i   (wr && win && offs == WOFF_DB_EN && own),
      .wdata_i   (bus_wdata_i[DB_W-1:0]),
      .cause_o   (db_cause[c]),
      .en_o      (db_en[c]),
      .hit_o     (db_hit[c])
    );
  end

  assign hit = src_hit | db_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (!win) begin
        if (offs == OFF_CTRL) begin
          bus_rdata_o[7:0]  = 8'(NUM_SRC);
          bus_rdata_o[11:8] = 4'(NUM_CPUS);
        end else if (route_hit && route_ok) begin
          for (int c = 0; c < NUM_CPUS; c++) bus_rdata_o[c] = unmask_q[c][route_idx];
        end
      end else begin
        case (offs)
          WOFF_ACK:      bus_rdata_o[9:0]      = first_code[bus_cpu_i];
          WOFF_DB_CAUSE: bus_rdata_o[DB_W-1:0] = db_cause[bus_cpu_i];
          WOFF_DB_EN:    bus_rdata_o[DB_W-1:0] = db_en[bus_cpu_i];
          default:       bus_rdata_o           = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_mask_intc_chk.sv
module dual_mask_intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 2,
  parameter int unsigned NUM_SRC  = 40
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_req_i,
  input logic                        bus_we_i,
  input logic [$clog2(NUM_CPUS)-1:0] bus_cpu_i,
  input logic [11:0]                 bus_addr_i,
  input logic [31:0]                 bus_wdata_i,
  input logic [31:0]                 bus_rdata_o,
  input logic [NUM_SRC-1:0]          glb_en_q,
  input logic [NUM_CPUS-1:0][NUM_SRC-1:0] unmask_q,
  input logic [NUM_CPUS-1:0]         hit,
  input logic [NUM_CPUS-1:0]         irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic wr_main, wr_win, ok;
  logic [IDX_W-1:0] n;
  assign wr_main = bus_req_i && bus_we_i && !bus_addr_i[11];
  assign wr_win  = bus_req_i && bus_we_i && bus_addr_i[11];
  assign ok      = bus_wdata_i < 32'(NUM_SRC);
  assign n       = bus_wdata_i[IDX_W-1:0];

  p_glb_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main && ok && bus_addr_i[10:0] == OFF_GEN_SET) |=> glb_en_q[$past(n)]);

  p_glb_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main && ok && bus_addr_i[10:0] == OFF_GEN_CLR) |=> !glb_en_q[$past(n)]);

  p_unmask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_win && ok && bus_addr_i[10:0] == WOFF_UNMASK) |=> unmask_q[$past(bus_cpu_i)][$past(n)]);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
    p_other_cpu_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_win && (bus_addr_i[10:0] == WOFF_UNMASK || bus_addr_i[10:0] == WOFF_MASK)
        && int'(bus_cpu_i) != c) |=> unmask_q[c] == $past(unmask_q[c]));

    p_irq_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] == $past(hit[c]));
  end

  p_ack_qualified_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i[11] && bus_addr_i[10:0] == WOFF_ACK
      && bus_rdata_o != {22'b0, ACK_NONE})
    |-> glb_en_q[bus_rdata_o[IDX_W-1:0]] && unmask_q[bus_cpu_i][bus_rdata_o[IDX_W-1:0]]);

  p_oob_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_main && !ok && (bus_addr_i[10:0] == OFF_GEN_SET || bus_addr_i[10:0] == OFF_GEN_CLR))
    |=> glb_en_q == $past(glb_en_q));
endmodule

bind dual_mask_intc dual_mask_intc_chk #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_cpu_i  (bus_cpu_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .glb_en_q   (glb_en_q),
  .unmask_q   (unmask_q),
  .hit        (hit),
  .irq_o      (irq_o)
);

// File: tb/dual_mask_intc_test.sv
module dual_mask_intc_test;
  localparam int NC = 2;
  localparam int NS = 40;
  localparam int NP = 28;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic [NS-NP-1:0] src_glb = '0;
  logic [NC*NP-1:0] src_pcpu = '0;
  logic req = 1'b0, we = 1'b0;
  logic cpu = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NC-1:0] irq;

  dual_mask_intc uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_glb_i(src_glb), .src_pcpu_i(src_pcpu),
    .bus_req_i(req), .bus_we_i(we), .bus_cpu_i(cpu), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit glb[NS];
  bit um[NC][NS];
  logic [7:0] cause[NC], dben[NC];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit line(int c, int s);
    return (s < NP) ? src_pcpu[c*NP + s] : src_glb[s - NP];
  endfunction

  function automatic int exp_ack(int c);
    for (int s = 0; s < NS; s++) if (line(c, s) && glb[s] && um[c][s]) return s;
    return 'h3FF;
  endfunction

  function automatic bit exp_irq(int c);
    return (exp_ack(c) != 'h3FF) || ((cause[c] & dben[c]) != 0);
  endfunction

  task automatic bus_wr(input int c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; cpu = c[0]; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input int c, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; cpu = c[0]; addr = a;
    #2 d = rdata;
    req = 0;
  endtask

  task automatic op_gen(input bit set, input int n);
    bus_wr(0, set ? 12'h030 : 12'h034, n);
    if (n < NS) glb[n] = set;
  endtask

  task automatic op_mask(input int c, input bit unm, input int n);
    bus_wr(c, unm ? 12'h848 : 12'h84C, n);
    if (n < NS) um[c][n] = unm;
  endtask

  task automatic op_route(input int s, input logic [3:0] bits);
    bus_wr(0, 12'(12'h100 + 4*s), {28'b0, bits});
    if (s >= NP) for (int c = 0; c < NC; c++) um[c][s] = bits[c];
  endtask

  task automatic op_trig(input logic [31:0] d);
    bus_wr(0, 12'h004, d);
    for (int c = 0; c < NC; c++) if (d[16+c]) cause[c] |= d[7:0];
  endtask

  task automatic op_cause(input int c, input logic [7:0] d);
    bus_wr(c, 12'h808, {24'b0, d});
    cause[c] &= d;
  endtask

  task automatic op_dben(input int c, input logic [7:0] d);
    bus_wr(c, 12'h80C, {24'b0, d});
    dben[c] = d;
  endtask

  task automatic check_route(input int s, input string tag);
    logic [31:0] d;
    bus_rd(0, 12'(12'h100 + 4*s), d);
    chk(d == {30'b0, um[1][s], um[0][s]}, tag, d, {um[1][s], um[0][s]});
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    @(negedge clk);
    #1;
    for (int c = 0; c < NC; c++) chk(irq[c] == exp_irq(c), tag, irq[c], exp_irq(c));
    for (int c = 0; c < NC; c++) begin
      bus_rd(c, 12'h844, d);
      chk(d == 32'(exp_ack(c)), "R6 ack", d, exp_ack(c));
      bus_rd(c, 12'h808, d);
      chk(d == {24'b0, cause[c]}, "R8 cause", d, cause[c]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NC; c++) begin
      cause[c] = 0; dben[c] = 0;
      for (int s = 0; s < NS; s++) um[c][s] = 0;
    end
    for (int s = 0; s < NS; s++) glb[s] = 0;

    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    @(negedge clk);
    chk(irq == 0, "R1 irq", irq, 0);
    for (int c = 0; c < NC; c++) begin
      bus_rd(c, 12'h844, d); chk(d == 32'h3FF, "R1 ack", d, 'h3FF);
      bus_rd(c, 12'h80C, d); chk(d == 0, "R1 db enable", d, 0);
      bus_rd(c, 12'h808, d); chk(d == 0, "R1 db cause", d, 0);
    end
    check_route(33, "R1 route");

    // R12 control
    bus_rd(0, 12'h000, d);
    chk(d == 32'h228, "R12 ctrl", d, 'h228);

    // R2 both levels needed
    src_glb[2] = 1;               // source 30
    op_gen(1, 30);
    check_all("R2 enable only");
    op_mask(0, 1, 30);
    check_all("R3 unmask cpu0");
    chk(irq == 2'b01, "R3 other cpu", irq, 2'b01);
    op_gen(0, 30);
    check_all("R2 global clear");

    // R10 latency of a register write
    bus_wr(0, 12'h030, 30); glb[30] = 1;
    #1 chk(irq[0] == 1'b0, "R10 write +1", irq[0], 0);
    @(negedge clk); #1 chk(irq[0] == 1'b1, "R10 write +2", irq[0], 1);
    // R10 latency of a line change
    @(negedge clk); src_glb[2] = 0;
    #1 chk(irq[0] == 1'b1, "R10 line +0", irq[0], 1);
    @(negedge clk); #1 chk(irq[0] == 1'b0, "R10 line +1", irq[0], 0);
    op_mask(0, 0, 30);

    // R4 routing of a shared source
    src_glb[7] = 1; op_gen(1, 35);
    op_route(35, 4'b0010);
    check_route(35, "R4 route readback");
    check_all("R4 routed to cpu1");
    op_route(35, 4'b0000);

    // R5 private source: separate lines, routing ignored
    op_route(5, 4'b0011);
    check_route(5, "R5 route ignored");
    op_gen(1, 5); op_mask(1, 1, 5);
    src_pcpu[0*NP + 5] = 1;
    check_all("R5 cpu0 line");
    chk(irq == 2'b00, "R5 cpu0 line silent", irq, 0);
    src_pcpu[1*NP + 5] = 1;
    check_all("R5 cpu1 line");

    // R6 lowest first
    op_gen(1, 3); op_gen(1, 9); op_mask(1, 1, 3); op_mask(1, 1, 9);
    src_pcpu[1*NP + 9] = 1; src_pcpu[1*NP + 3] = 1;
    check_all("R6 lowest");
    src_pcpu = '0;

    // R11 out of range (76 would alias to 12 if truncated)
    op_mask(0, 1, 12); src_pcpu[12] = 1;
    op_gen(1, 76);
    check_all("R11 oob enable");
    op_mask(0, 1, 64 + 20); op_gen(1, 20); src_pcpu[20] = 1;
    check_all("R11 oob unmask");
    src_pcpu = '0;

    // R7 R8 R9 doorbells
    op_trig(32'h0001_0005);
    check_all("R7 trigger cpu0");
    op_dben(0, 8'h04);
    check_all("R9 doorbell enabled");
    bus_rd(0, 12'h80C, d); chk(d == 32'h04, "R9 enable readback", d, 4);
    op_cause(0, 8'hFB);
    check_all("R8 clear by zero");
    op_trig(32'h0003_0080);
    op_dben(1, 8'h80);
    check_all("R7 trigger both");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int n, c;
      n = ($urandom_range(0, 9) == 0) ? 64 + $urandom_range(0, 40) : $urandom_range(0, NS + 4);
      c = $urandom_range(0, NC - 1);
      case ($urandom_range(0, 7))
        0: op_gen(1, n);
        1: op_gen(0, n);
        2: op_mask(c, 1'($urandom_range(0, 1)), n);
        3: begin
          n = $urandom_range(0, NS - 1);
          op_route(n, 4'($urandom));
          check_route(n, "R4 R5 random route");
        end
        4: begin
          @(negedge clk);
          src_glb  = $urandom & $urandom;
          src_pcpu = {$urandom & $urandom, $urandom & $urandom};
        end
        5: op_trig($urandom & 32'h0003_00FF);
        6: op_cause(c, 8'($urandom));
        default: op_dben(c, 8'($urandom & $urandom));
      endcase
      check_all("R2 R3 R9 random irq");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule